// File: doc/BRIEF.md
# Conversion Word Serial Readout

This block hands a finished 24-bit conversion result to a host over one output line that does two jobs. While no result is waiting, the line sits high. When the converter core pulses its new-result strobe, the block takes a copy of the word and pulls the line low to tell the host that data is ready. The host then keeps chip select high and issues serial clocks. Each rising serial clock edge moves the next bit onto the line, most significant bit first. The host latches each bit on the following falling edge.

After the 24th falling edge the line goes high again. A result that arrives during a readout does not disturb the word being shifted. It is held in a one-deep pending slot, where a later result replaces an earlier one. It is announced as soon as the current readout ends. The serial clock and chip select are sampled in the system clock domain, so the host's serial clock must be much slower than the system clock.

Top module: `conv_readout`

## Requirements
- R1: After reset `sdo_rdy` is 1 and no word is pending.
- R2: A `conv_strobe` pulse while no readout is active captures `conv_word`. `sdo_rdy` is 0 from the next clock until the first rising serial edge.
- R3: Serial clock edges seen while `cs` is 0 are ignored. They neither shift the word nor count toward the 24 bits.
- R4: With `cs` at 1, each rising `sclk` edge drives the next bit of the captured word onto `sdo_rdy`. The first edge gives bit 23 and the 24th gives bit 0. The bit holds until the next rising edge, so it can be sampled on the falling edge.
- R5: The falling `sclk` edge after the 24th bit returns `sdo_rdy` to 1 when nothing is pending. Further serial edges leave it at 1.
- R6: A strobe that arrives during a readout does not change any of the 24 bits being shifted out.
- R7: A strobe during a readout is held pending, and a later one replaces it. At the end of the readout the pending word is captured and `sdo_rdy` goes to 0.
- R8: A strobe in the same clock as the final falling edge is captured directly, and `sdo_rdy` stays announced at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select; conversion readout takes place while it is 1 |
| sclk | input | 1 | Host serial clock, sampled by `clk` |
| conv_strobe | input | 1 | One-clock pulse: a new conversion word is valid |
| conv_word | input | 24 | Conversion result from the converter core |
| sdo_rdy | output | 1 | Ready flag (low) and serial data line |

## Verification
The assertions assume that `sclk` stays at each level for at least two system clocks. They also assume that `conv_strobe` is a single-cycle pulse and that `cs` changes only while `sclk` is low, so that changing chip select never creates a serial edge. The bench drives `sclk` at three system clocks per phase and changes `cs` only with `sclk` held low. It times strobes to fall idle, in the middle of a readout, and exactly on the final falling edge.

// File: rtl/conv_readout_pkg.sv
package conv_readout_pkg;
  typedef enum logic {RD_IDLE = 1'b0, RD_BUSY = 1'b1} rd_state_e;

  // True when every bit of a BITS-long word has been driven out.
  function automatic logic all_bits_sent(input int unsigned sent, input int unsigned bits);
    return sent == bits;
  endfunction
endpackage

// File: rtl/crd_edge_det.sv
module crd_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk;
  end

  assign rise = cs & sclk & ~sclk_d;
  assign fall = cs & ~sclk & sclk_d;
endmodule

// File: rtl/crd_pend_slot.sv
module crd_pend_slot #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set,
  input  logic [W-1:0] set_word,
  input  logic         take,
  output logic         valid,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      word  <= '0;
    end else if (set) begin
      valid <= 1'b1;
      word  <= set_word;
    end else if (take) begin
      valid <= 1'b0;
    end
  end

  assert_pending_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> valid && word == $past(set_word));
endmodule

// File: rtl/crd_shifter.sv
module crd_shifter
  import conv_readout_pkg::*;
#(
  parameter int W = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [W-1:0]           load_word,
  input  logic                   rise,
  input  logic                   fall,
  output logic                   sdo,
  output logic                   busy,
  output logic                   done,
  output logic [$clog2(W+1)-1:0] sent
);
  localparam int CW = $clog2(W + 1);

  rd_state_e st;
  logic [W-1:0] shreg;
  logic         full;
  logic         step;

  assign full = all_bits_sent(int'(sent), W);
  assign busy = (st == RD_BUSY);
  assign step = busy & rise & ~full;
  assign done = busy & fall & full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= RD_IDLE;
      shreg <= '0;
      sent  <= '0;
      sdo   <= 1'b1;
    end else if (load) begin
      st    <= RD_BUSY;
      shreg <= load_word;
      sent  <= '0;
      sdo   <= 1'b0;
    end else if (step) begin
      sdo   <= shreg[W-1];
      shreg <= {shreg[W-2:0], 1'b0};
      sent  <= sent + CW'(1);
    end else if (done) begin
      st    <= RD_IDLE;
      sdo   <= 1'b1;
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sdo);
  assert_announce_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !sdo && sent == '0);
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sent <= CW'(W));
  assert_msb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> sdo == $past(shreg[W-1]));
  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !load |=> sdo && !busy);
endmodule

// File: rtl/conv_readout.sv
module conv_readout #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sclk,
  input  logic              conv_strobe,
  input  logic [WORD_W-1:0] conv_word,
  output logic              sdo_rdy
);
  localparam int CW = $clog2(WORD_W + 1);

  logic              rise_w, fall_w;
  logic              busy_w, done_w;
  logic [CW-1:0]     sent_w;
  logic              pend_valid;
  logic [WORD_W-1:0] pend_word;
  logic              load_w;
  logic [WORD_W-1:0] load_word_w;
  logic              pend_set_w;

  crd_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk),
    .rise(rise_w), .fall(fall_w)
  );

  // A fresh strobe takes priority over the pending slot.
  assign load_w      = (conv_strobe & ~busy_w) | (done_w & (conv_strobe | pend_valid));
  assign load_word_w = conv_strobe ? conv_word : pend_word;
  assign pend_set_w  = conv_strobe & busy_w & ~done_w;

  crd_pend_slot #(.W(WORD_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .set(pend_set_w), .set_word(conv_word),
    .take(done_w), .valid(pend_valid), .word(pend_word)
  );

  crd_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_w), .load_word(load_word_w),
    .rise(rise_w), .fall(fall_w), .sdo(sdo_rdy), .busy(busy_w),
    .done(done_w), .sent(sent_w)
  );

  assert_cs_low_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w && !cs |=> $stable(sent_w));
  assert_same_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_w && conv_strobe |=> !pend_valid && !sdo_rdy && busy_w);
  assert_no_pending_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> !pend_valid);
endmodule

// File: tb/test_conv_readout.sv
module test_conv_readout;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b1;
  logic sclk = 1'b0;
  logic conv_strobe = 1'b0;
  logic [23:0] conv_word = '0;
  logic sdo_rdy;

  int checks = 0;
  int errors = 0;
  bit done_run = 0;

  always #2 clk = ~clk;

  conv_readout i_conv_readout (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk),
    .conv_strobe(conv_strobe), .conv_word(conv_word), .sdo_rdy(sdo_rdy)
  );

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference model, updated on each rising clock.
  bit          m_busy = 0;
  int          m_cnt = 0;
  logic [23:0] m_word = '0;
  logic        m_sdo = 1'b1;
  logic        m_prev = 1'b0;
  logic [23:0] m_pend[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_sdo = 1'b1; m_prev = 1'b0; m_pend.delete();
    end else begin
      bit r, f, fin;
      r = cs && sclk && !m_prev;
      f = cs && !sclk && m_prev;
      m_prev = sclk;
      fin = m_busy && f && m_cnt == 24;
      if (!m_busy && conv_strobe) begin
        m_busy = 1; m_word = conv_word; m_cnt = 0; m_sdo = 1'b0;
      end else if (fin) begin
        if (conv_strobe) begin
          m_word = conv_word; m_cnt = 0; m_sdo = 1'b0; m_pend.delete();
        end else if (m_pend.size() > 0) begin
          m_word = m_pend.pop_front(); m_cnt = 0; m_sdo = 1'b0;
        end else begin
          m_busy = 0; m_sdo = 1'b1;
        end
      end else if (m_busy) begin
        if (r && m_cnt < 24) begin
          m_sdo = m_word[23 - m_cnt];
          m_cnt++;
        end
        if (conv_strobe) begin
          m_pend.delete();
          m_pend.push_back(conv_word);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_run)
      check(sdo_rdy === m_sdo, "model R4/R5/R7", {23'd0, sdo_rdy}, {23'd0, m_sdo});
  end

  task automatic strobe(input logic [23:0] w);
    @(negedge clk); conv_strobe = 1'b1; conv_word = w;
    @(negedge clk); conv_strobe = 1'b0;
  endtask

  // Host readout; a strobe can be issued together with the falling edge of bit s1 or s2.
  task automatic read_word(output logic [23:0] v, input int s1, input logic [23:0] w1,
                           input int s2, input logic [23:0] w2);
    v = '0;
    cs = 1'b1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); sclk = 1'b1;
      repeat (2) @(negedge clk);
      @(negedge clk);
      v = {v[22:0], sdo_rdy};
      sclk = 1'b0;
      if (i == s1) begin conv_strobe = 1'b1; conv_word = w1; end
      else if (i == s2) begin conv_strobe = 1'b1; conv_word = w2; end
      @(negedge clk); conv_strobe = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 24'd0, 24'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sdo_rdy === 1'b1, "R1 idle high after reset", {23'd0, sdo_rdy}, 24'd1);

    strobe(24'hA5C3F1);
    @(negedge clk);
    check(sdo_rdy === 1'b0, "R2 ready announced", {23'd0, sdo_rdy}, 24'd0);

    cs = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); sclk = 1'b1; repeat (3) @(negedge clk); sclk = 1'b0; repeat (2) @(negedge clk);
    end
    cs = 1'b1;
    @(negedge clk);
    check(sdo_rdy === 1'b0, "R3 cs low ignored", {23'd0, sdo_rdy}, 24'd0);

    read_word(got, -1, '0, -1, '0);
    check(got === 24'hA5C3F1, "R3 R4 word msb first", got, 24'hA5C3F1);
    repeat (2) @(negedge clk);
    check(sdo_rdy === 1'b1, "R5 released high", {23'd0, sdo_rdy}, 24'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); sclk = 1'b1; repeat (3) @(negedge clk); sclk = 1'b0; repeat (2) @(negedge clk);
    end
    check(sdo_rdy === 1'b1, "R5 extra clocks ignored", {23'd0, sdo_rdy}, 24'd1);

    strobe(24'h123456);
    read_word(got, 5, 24'h0F0F0F, 10, 24'hFEDCBA);
    check(got === 24'h123456, "R6 word not corrupted", got, 24'h123456);
    repeat (2) @(negedge clk);
    check(sdo_rdy === 1'b0, "R7 pending announced", {23'd0, sdo_rdy}, 24'd0);
    read_word(got, -1, '0, -1, '0);
    check(got === 24'hFEDCBA, "R7 latest pending wins", got, 24'hFEDCBA);
    repeat (2) @(negedge clk);
    check(sdo_rdy === 1'b1, "R5 idle after pending read", {23'd0, sdo_rdy}, 24'd1);

    strobe(24'h800001);
    read_word(got, 23, 24'h7FFFFE, -1, '0);
    check(got === 24'h800001, "R8 first word", got, 24'h800001);
    repeat (2) @(negedge clk);
    check(sdo_rdy === 1'b0, "R8 same-cycle strobe announced", {23'd0, sdo_rdy}, 24'd0);
    read_word(got, -1, '0, -1, '0);
    check(got === 24'h7FFFFE, "R8 same-cycle word", got, 24'h7FFFFE);
    repeat (3) @(negedge clk);

    done_run = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule